// File: doc/BRIEF.md
# SPI-Mode SD Card Read Data Streamer

This block plays the card's part during the data phase of a read in SPI mode. A command responder arms it after it has answered a read command for which data is ready. From then on, every SPI byte exchange with the host moves the streamer forward by one byte. Each block is sent as a 0xFE start token, then up to 512 bytes taken from a backend byte source, then a two-byte CRC16 that is computed while the data passes through. When a transfer that was started by a multi-block read fills a whole block, the streamer inserts a 0xFF gap byte and a fresh token, then sends the next block.

While the read is in progress, the streamer checks every byte the host sends. A 0x4C byte, which is the first byte of the stop command, ends the read at once. The block then pulses a flag so that the command responder can treat that byte as the start of a new command frame and add its extra idle byte. All other host bytes are ignored. Decoding the rest of the command frame is the responder's job.

Top module: `sd_rd_streamer`

## Requirements
- R1: After reset, `card_byte` reads 0xFF, `busy` is low, and `src_pop`, `stop_hit` and `blk_done` are low.
- R2: A `start_read` pulse while idle arms the streamer. The next exchange returns the start token 0xFE. Each following exchange returns `src_byte` exactly as presented and raises `src_pop` for that exchange only.
- R3: A block's data phase ends after 512 data bytes, or at the first data byte that has `src_last` high, whichever comes first. The exchange after it returns a CRC byte.
- R4: The CRC is CRC-16 with polynomial 0x1021, initial value 0 and no reflection, taken over the block's data bytes. It is sent in the two exchanges after the last data byte, high byte first. The nine ASCII bytes "123456789" give 0x31C3.
- R5: Every block's CRC starts again from zero, so a later block's CRC depends only on that block's own data.
- R6: After the second CRC byte, the streamer behaves in one of two ways:
  - If the block held 512 bytes and `single_rd` was low at arming, it returns one 0xFF gap byte and then 0xFE, and streams the next block.
  - Otherwise it goes idle (`busy` low, replies 0xFF).
  
  `blk_done` pulses for one cycle after each second CRC byte.
- R7: A host byte of 0x4C in the gap, token, data or CRC phase has the following effects on that exchange:
  - the reply is 0xFF;
  - no byte is popped;
  - `busy` drops;
  - `stop_hit` pulses for one cycle;
  - the byte counter is cleared, so a later read again runs full 512-byte blocks.
- R8: Host bytes other than 0x4C have no effect on the data stream, and a 0x4C while idle has no effect.
- R9: On cycles without `xfer_valid`, `card_byte` holds its value and nothing advances.
- R10: `start_read` is ignored while `busy` is high, and the single/multi choice made at arming is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_read | input | 1 | Arm a read; sampled while idle |
| single_rd | input | 1 | High when the read was a single-block read (sampled with `start_read`) |
| xfer_valid | input | 1 | One SPI byte exchange completes this cycle |
| host_byte | input | 8 | Byte received from the host in this exchange |
| card_byte | output | 8 | Byte returned for the last exchange (registered) |
| src_byte | input | 8 | Current byte offered by the backend |
| src_last | input | 1 | `src_byte` is the backend's final byte |
| src_pop | output | 1 | Backend byte consumed this cycle |
| busy | output | 1 | Streamer is inside a read phase |
| stop_hit | output | 1 | One-cycle pulse after a stop byte aborted the read |
| blk_done | output | 1 | One-cycle pulse after a block's second CRC byte |

## Verification
`card_byte`, `stop_hit`, `blk_done` and `busy` all take the value for an exchange at the rising edge that samples `xfer_valid`. They are due one cycle after the stimulus, so the bench drives each exchange at a falling edge and reads these outputs at the next falling edge. `src_pop` is combinational and belongs to the same cycle as the exchange, so it is checked 1 ns after the inputs are applied. Exchanges are separated by a quiet cycle, and `card_byte` is compared against its previous value at that point to show that it held.

// File: rtl/sd_rd_pkg.sv
package sd_rd_pkg;

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] START_TOK  = 8'hFE;
  localparam logic [7:0] STOP_LEAD  = 8'h4C;
  localparam logic [15:0] CRC_POLY  = 16'h1021;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GAP,
    PH_TOKEN,
    PH_DATA,
    PH_CRC
  } rd_phase_t;

  // One byte of MSB-first CRC-16 (poly 0x1021, no reflection).
  function automatic logic [15:0] crc16_next(input logic [15:0] cur, input logic [7:0] din);
    logic [15:0] c;
    logic fb;
    c = cur;
    for (int b = 7; b >= 0; b--) begin
      fb = c[15] ^ din[b];
      c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return c;
  endfunction

endpackage

// File: rtl/sd_rd_crc16.sv
module sd_rd_crc16
  import sd_rd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic [7:0]  din,
  input  logic        shift,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n)     crc <= '0;
    else if (clr)   crc <= '0;
    else if (upd)   crc <= crc16_next(crc, din);
    else if (shift) crc <= {crc[7:0], 8'h00};
  end
endmodule

// File: rtl/sd_rd_counter.sv
module sd_rd_counter #(
  parameter int MAX_CNT = 512,
  parameter int CNT_W   = $clog2(MAX_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last,
  output logic             full
);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(MAX_CNT - 1);
  localparam logic [CNT_W-1:0] FULL_V = CNT_W'(MAX_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == LAST_V);
  assign full    = (cnt == FULL_V);
endmodule

// File: rtl/sd_rd_streamer.sv
module sd_rd_streamer
  import sd_rd_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int CNT_W       = $clog2(BLOCK_BYTES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_read,
  input  logic       single_rd,
  input  logic       xfer_valid,
  input  logic [7:0] host_byte,
  output logic [7:0] card_byte,
  input  logic [7:0] src_byte,
  input  logic       src_last,
  output logic       src_pop,
  output logic       busy,
  output logic       stop_hit,
  output logic       blk_done
);

  rd_phase_t        phase, phase_nx;
  logic             single_q;
  logic             crc_half;
  logic [15:0]      crc_val;
  logic [CNT_W-1:0] blk_cnt;
  logic             cnt_at_last, cnt_full;
  logic [7:0]       reply;

  // Named internal events
  logic stop_now;     // abort request on this exchange
  logic step;         // normal advance on this exchange
  logic arm_now;      // start accepted
  logic data_end;     // current data byte closes the block
  logic crc_finish;   // second CRC byte goes out now

  assign busy       = (phase != PH_IDLE);
  assign stop_now   = xfer_valid && busy && (host_byte == STOP_LEAD);
  assign step       = xfer_valid && !stop_now;
  assign arm_now    = (phase == PH_IDLE) && start_read;
  assign data_end   = src_last || cnt_at_last;
  assign crc_finish = step && (phase == PH_CRC) && crc_half;
  assign src_pop    = step && (phase == PH_DATA);

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:  if (start_read) phase_nx = PH_TOKEN;
      PH_GAP:   if (step) phase_nx = PH_TOKEN;
      PH_TOKEN: if (step) phase_nx = PH_DATA;
      PH_DATA:  if (step && data_end) phase_nx = PH_CRC;
      PH_CRC:   if (crc_finish) phase_nx = (cnt_full && !single_q) ? PH_GAP : PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
    if (stop_now) phase_nx = PH_IDLE;
  end

  always_comb begin
    unique case (phase)
      PH_TOKEN: reply = START_TOK;
      PH_DATA:  reply = src_byte;
      PH_CRC:   reply = crc_val[15:8];
      default:  reply = FILL_BYTE;
    endcase
    if (stop_now) reply = FILL_BYTE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      single_q  <= 1'b0;
      crc_half  <= 1'b0;
      card_byte <= FILL_BYTE;
      stop_hit  <= 1'b0;
      blk_done  <= 1'b0;
    end else begin
      phase    <= phase_nx;
      stop_hit <= stop_now;
      blk_done <= crc_finish;
      if (arm_now) single_q <= single_rd;
      if (xfer_valid) card_byte <= reply;
      if (stop_now) crc_half <= 1'b0;
      else if (step && phase == PH_CRC) crc_half <= ~crc_half;
    end
  end

  sd_rd_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stop_now),
    .upd   (src_pop),
    .din   (src_byte),
    .shift (step && phase == PH_CRC),
    .crc   (crc_val)
  );

  sd_rd_counter #(.MAX_CNT(BLOCK_BYTES), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (stop_now || crc_finish),
    .inc     (src_pop),
    .cnt     (blk_cnt),
    .at_last (cnt_at_last),
    .full    (cnt_full)
  );

endmodule

// File: rtl/sd_rd_streamer_chk.sv
module sd_rd_streamer_chk #(
  parameter int BLOCK_BYTES = 512,
  parameter int CNT_W       = $clog2(BLOCK_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_valid,
  input logic [7:0]       host_byte,
  input logic [7:0]       card_byte,
  input logic             src_pop,
  input logic             busy,
  input logic             stop_hit,
  input logic             blk_done,
  input logic [CNT_W-1:0] blk_cnt,
  input logic [15:0]      crc_val
);
  // R9
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid |=> $stable(card_byte));

  // R2
  pop_in_exchange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |-> (xfer_valid && busy));

  // R7
  stop_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && busy && host_byte == 8'h4C) |-> !src_pop);

  // R7
  stop_lands_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |-> (!busy && card_byte == 8'hFF));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_cnt <= CNT_W'(BLOCK_BYTES));

  // R5
  crc_empty_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (crc_val == 16'h0000));
endmodule

bind sd_rd_streamer sd_rd_streamer_chk #(.BLOCK_BYTES(BLOCK_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_valid (xfer_valid),
  .host_byte  (host_byte),
  .card_byte  (card_byte),
  .src_pop    (src_pop),
  .busy       (busy),
  .stop_hit   (stop_hit),
  .blk_done   (blk_done),
  .blk_cnt    (blk_cnt),
  .crc_val    (crc_val)
);

// File: tb/sd_rd_streamer_test.sv
`timescale 1ns/1ps
module sd_rd_streamer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_read, single_rd, xfer_valid, src_last;
  logic [7:0] host_byte, card_byte, src_byte;
  logic       src_pop, busy, stop_hit, blk_done;

  always #4 clk = ~clk;

  // Backend byte source model
  logic [7:0] bdat [0:2047];
  int ptr;
  int last_at;
  assign src_byte = bdat[ptr % 2048];
  assign src_last = (ptr == last_at);
  always @(posedge clk) if (src_pop) ptr <= ptr + 1;

  sd_rd_streamer uut (
    .clk(clk), .rst_n(rst_n), .start_read(start_read), .single_rd(single_rd),
    .xfer_valid(xfer_valid), .host_byte(host_byte), .card_byte(card_byte),
    .src_byte(src_byte), .src_last(src_last), .src_pop(src_pop),
    .busy(busy), .stop_hit(stop_hit), .blk_done(blk_done)
  );

  int checks = 0, errors = 0;
  // reference state: 0 idle, 1 gap, 2 token, 3 data, 4 crc
  int mst = 0, mcnt = 0, mcrc = 0, mhalf = 0, mblk = 0;
  bit msingle = 0;
  int prev_out = 8'hFF;
  int last_out;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_crc(int c, int d);
    int x = (c ^ (d << 8)) & 16'hFFFF;
    for (int k = 0; k < 8; k++)
      x = (x & 16'h8000) ? (((x << 1) ^ 16'h1021) & 16'hFFFF) : ((x << 1) & 16'hFFFF);
    return x;
  endfunction

  task automatic arm(bit s);
    @(negedge clk);
    start_read = 1'b1; single_rd = s;
    if (mst == 0) begin mst = 2; msingle = s; mblk = 0; end
    @(negedge clk);
    start_read = 1'b0;
    chk(busy == (mst != 0), "R10", busy, mst != 0);
  endtask

  task automatic exch(int hb);
    int exp_b = 8'hFF;
    bit exp_pop = 0, exp_stop = 0, exp_done = 0;
    string tag = "R8";
    @(negedge clk);
    chk(card_byte == prev_out, "R9", card_byte, prev_out);
    if (mst != 0 && hb == 8'h4C) begin
      exp_stop = 1; mst = 0; mcnt = 0; mcrc = 0; mhalf = 0; tag = "R7";
    end else begin
      case (mst)
        1: begin exp_b = 8'hFF; mst = 2; tag = "R6"; end
        2: begin exp_b = 8'hFE; mst = 3; tag = "R2"; end
        3: begin
          exp_b = bdat[ptr % 2048]; exp_pop = 1; tag = "R2";
          mcrc = ref_crc(mcrc, exp_b); mcnt++;
          if (ptr == last_at || mcnt == 512) mst = 4;
        end
        4: begin
          exp_b = (mcrc >> 8) & 8'hFF; mcrc = (mcrc << 8) & 16'hFFFF;
          if (mhalf == 0) begin mhalf = 1; tag = "R3"; end
          else begin
            tag = (mblk > 0) ? "R5" : "R4";
            exp_done = 1;
            mst = (mcnt == 512 && !msingle) ? 1 : 0;
            mcnt = 0; mhalf = 0; mblk++;
          end
        end
        default: exp_b = 8'hFF;
      endcase
    end
    xfer_valid = 1'b1; host_byte = hb[7:0];
    #1 chk(src_pop == exp_pop, tag, src_pop, exp_pop);
    @(negedge clk);
    xfer_valid = 1'b0;
    chk(card_byte == exp_b, tag, card_byte, exp_b);
    chk(stop_hit == exp_stop, "R7", stop_hit, exp_stop);
    chk(blk_done == exp_done, "R6", blk_done, exp_done);
    chk(busy == (mst != 0), tag, busy, mst != 0);
    prev_out = exp_b;
    last_out = card_byte;
  endtask

  function automatic int noise(int i);
    int v = (i * 37 + 11) & 8'hFF;
    return (v == 8'h4C) ? 8'h4D : v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int crc_hi, crc_lo;
    rst_n = 1'b0; start_read = 0; single_rd = 0; xfer_valid = 0; host_byte = 0;
    ptr = 0; last_at = -1;
    for (int k = 0; k < 2048; k++) bdat[k] = 8'((k * 7 + 3) & 8'hFF);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(card_byte == 8'hFF, "R1", card_byte, 8'hFF);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(src_pop == 1'b0 && stop_hit == 1'b0 && blk_done == 1'b0, "R1", src_pop, 0);

    // R4 known vector, single block ended early by src_last (R3)
    for (int k = 0; k < 9; k++) bdat[k] = 8'(8'h31 + k);
    ptr = 0; last_at = 8;
    arm(1'b1);
    for (int i = 0; i < 12; i++) begin
      exch(noise(i));
      if (i == 10) crc_hi = last_out;
      if (i == 11) crc_lo = last_out;
    end
    chk(((crc_hi << 8) | crc_lo) == 16'h31C3, "R4", (crc_hi << 8) | crc_lo, 16'h31C3);
    exch(8'h00);  // idle after single block (R6)
    exch(8'h4C);  // stop byte while idle is ignored (R8)

    // Multi-block chain with fresh CRC per block, then abort in data (R5, R6, R7)
    for (int k = 0; k < 2048; k++) bdat[k] = 8'((k * 7 + 3) & 8'hFF);
    @(negedge clk); ptr = 0; last_at = -1;
    arm(1'b0);
    for (int i = 0; i < 515 + 515 + 1; i++) exch(noise(i));
    arm(1'b1);    // ignored while busy (R10)
    for (int i = 0; i < 100; i++) exch(8'hFF);
    exch(8'h4C);
    // Full single block returns to idle (R6)
    @(negedge clk); ptr = 0;
    arm(1'b1);
    for (int i = 0; i < 515; i++) exch(8'hFF);
    exch(8'hFF);
    // Abort in gap
    @(negedge clk); ptr = 0;
    arm(1'b0);
    for (int i = 0; i < 515; i++) exch(8'hFF);
    exch(8'h4C);
    // Abort in token
    arm(1'b0);
    exch(8'h4C);
    // Abort in CRC
    @(negedge clk); ptr = 0; last_at = 2;
    arm(1'b0);
    for (int i = 0; i < 5; i++) exch(8'hFF);
    exch(8'h4C);
    // Counter cleared by abort: next read runs a full 512-byte block and chains (R7)
    @(negedge clk); ptr = 0; last_at = -1;
    arm(1'b0);
    for (int i = 0; i < 518; i++) exch(noise(i));
    exch(8'h4C);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R7", busy, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule